// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Input Latch Controller

This block watches one external interrupt line for a chosen edge, rising or falling, and raises a request to the host when that edge arrives while interrupts are enabled. Two 8-bit digital input ports can optionally be frozen at the moment an edge is accepted. With freezing on, software reads a coherent snapshot that belongs to the interrupt it is servicing. With freezing off, software reads the inputs live. Two 8-bit output ports are held in registers that software can read back.

The host reaches the block through a plain register interface. It has a byte address, 32-bit write data, four byte enables and separate read and write strobes. Every access targets the aligned dword selected by address bits 5:2. A read returns its data in the clock cycle after the read strobe is sampled. An interrupt control/status dword holds the enable, the edge polarity, and two sticky flags that are cleared by writing 1: pending and missed. The missed flag records that another selected edge arrived before software cleared pending.

Top module: `irqlat_top`

## Requirements
- R1: After synchronous reset all readable registers are 0, the output ports are 0 and `irq_out` is low.
- R2: Dword 0x04 holds output port A in byte lane 0 and port B in byte lane 1. Each byte is written only when its byte enable is set, drives `out_a`/`out_b`, and reads back as written. Lanes 2 and 3 read 0.
- R3: Dword 0x34 reads the ASCII revision "A012", with 'A' in lane 0, giving 32'h32313041. Writes to it have no effect.
- R4: Byte lane 3 of dword 0x00 is the control byte. Bit 5 (data bit 29) enables latching and bit 6 (data bit 30) selects the falling edge. All other bits are ignored on write and read 0. Bit 6 is the same storage as polarity bit 6 of the status dword at 0x38.
- R5: `ext_irq` passes through two synchronizer flops. An edge of the selected polarity sets pending (bit 17 of dword 0x38) when the enable bit 12 is 1. Pending is visible by the third clock edge after the input changes. An edge of the other polarity does nothing.
- R6: While bit 12 is 0, edges on `ext_irq` set neither pending nor missed.
- R7: A selected, enabled edge that arrives while pending is already 1 sets missed (bit 23) and leaves pending set.
- R8: Writing 1 to bit 17 or bit 23 with byte enable 2 clears that flag. Writing 0 leaves it unchanged.
- R9: With latching on, lanes 0 and 1 of dword 0x00 return the synchronized `in_a`/`in_b` captured at the last accepted edge. A missed edge does not recapture. With latching off, they return the live synchronized inputs.
- R10: `irq_out` is high exactly when pending and enable are both 1.
- R11: All bits of dword 0x38 other than 6, 12, 17 and 23 read 0, as do unmapped dwords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address; bits 5:2 select the dword |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write lanes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on the next cycle |
| bus_rdata | output | 32 | Registered read data |
| ext_irq | input | 1 | External interrupt line, asynchronous |
| in_a | input | 8 | Input port A, asynchronous |
| in_b | input | 8 | Input port B, asynchronous |
| out_a | output | 8 | Output port A |
| out_b | output | 8 | Output port B |
| irq_out | output | 1 | Host interrupt request |

## Verification
The bench sweeps all four control-byte modes. In each mode it drives the selected edge with a new input pattern placed before the edge, and a different pattern after it. The two patterns show whether a read returns the captured snapshot or the live inputs. Each mode then sends the opposite edge, which must leave the flags alone, followed by a second selected edge, which must raise missed without recapturing. These steps separate polarity selection, latching and overrun handling. Separate passes cover edges while disabled, clearing one flag at a time, polarity written through the status dword, byte-lane writes to the output ports, the revision word and reserved bits.

// File: rtl/irqlat_pkg.sv
package irqlat_pkg;
    localparam int PORT_W  = 8;
    localparam int N_PORTS = 2;

    localparam logic [3:0] DW_IN  = 4'h0;
    localparam logic [3:0] DW_OUT = 4'h1;
    localparam logic [3:0] DW_REV = 4'hD;
    localparam logic [3:0] DW_CSR = 4'hE;

    localparam int CSR_POL_BIT  = 6;
    localparam int CSR_EN_BIT   = 12;
    localparam int CSR_PEND_BIT = 17;
    localparam int CSR_MISS_BIT = 23;
    localparam int CTL_LAT_BIT  = 29;
    localparam int CTL_POL_BIT  = 30;

    typedef enum logic [1:0] {
        MODE_RISE_LIVE  = 2'b00,
        MODE_RISE_FREEZE = 2'b01,
        MODE_FALL_LIVE  = 2'b10,
        MODE_FALL_FREEZE = 2'b11
    } edge_mode_t;

    typedef struct packed {
        logic en;
        logic pol;
        logic latch;
        logic pend;
        logic miss;
    } ctl_state_t;

    function automatic logic [31:0] csr_word(input ctl_state_t s);
        logic [31:0] w;
        w = '0;
        w[CSR_POL_BIT]  = s.pol;
        w[CSR_EN_BIT]   = s.en;
        w[CSR_PEND_BIT] = s.pend;
        w[CSR_MISS_BIT] = s.miss;
        return w;
    endfunction

    function automatic logic [7:0] ctrl_byte(input ctl_state_t s);
        edge_mode_t m;
        m = edge_mode_t'({s.pol, s.latch});
        return {1'b0, m, 5'b0};
    endfunction

    function automatic logic [31:0] rev_word(input logic [7:0] c2, input logic [7:0] c3);
        return {c3, c2, 8'h30, 8'h41};
    endfunction
endpackage

// File: rtl/irqlat_sync.sv
module irqlat_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irqlat_edge.sv
module irqlat_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic fall_sel,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    always_comb begin
        if (fall_sel) hit = prev_q & ~lvl;
        else          hit = ~prev_q & lvl;
    end
endmodule

// File: rtl/irqlat_capture.sv
module irqlat_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (cap) q <= d;
    end

    AST_HOLD_WITHOUT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(q)); // R9
endmodule

// File: rtl/irqlat_csr.sv
module irqlat_csr
    import irqlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [3:0]  dw,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic        hit,
    output logic        accept,
    output ctl_state_t  st
);
    logic en_q, pol_q, lat_q, pend_q, miss_q;
    logic wr_ctl, wr_b0, wr_b1, wr_b2;
    logic clr_pend, clr_miss, lost;

    assign wr_ctl = wr && (dw == DW_IN)  && be[3];
    assign wr_b0  = wr && (dw == DW_CSR) && be[0];
    assign wr_b1  = wr && (dw == DW_CSR) && be[1];
    assign wr_b2  = wr && (dw == DW_CSR) && be[2];

    assign clr_pend = wr_b2 && wdata[CSR_PEND_BIT];
    assign clr_miss = wr_b2 && wdata[CSR_MISS_BIT];
    assign accept   = hit && en_q && !pend_q;
    assign lost     = hit && en_q && pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pol_q  <= 1'b0;
            lat_q  <= 1'b0;
            pend_q <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            if (wr_ctl) begin
                pol_q <= wdata[CTL_POL_BIT];
                lat_q <= wdata[CTL_LAT_BIT];
            end else if (wr_b0) begin
                pol_q <= wdata[CSR_POL_BIT];
            end
            if (wr_b1) en_q <= wdata[CSR_EN_BIT];
            pend_q <= (pend_q & ~clr_pend) | accept;
            miss_q <= (miss_q & ~clr_miss) | lost;
        end
    end

    always_comb begin
        st.en    = en_q;
        st.pol   = pol_q;
        st.latch = lat_q;
        st.pend  = pend_q;
        st.miss  = miss_q;
    end

    AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(hit)); // R5
    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(en_q)); // R6
    AST_MISS_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        $rose(miss_q) |-> ($past(pend_q) && pend_q)); // R7
    AST_PEND_FALL_BY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> $past(wr && be[2] && wdata[CSR_PEND_BIT] && dw == DW_CSR)); // R8
endmodule

// File: rtl/irqlat_top.sv
module irqlat_top
    import irqlat_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] REV_C2      = 8'h31,
    parameter logic [7:0] REV_C3      = 8'h32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [3:0]  bus_be,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    input  logic        ext_irq,
    input  logic [7:0]  in_a,
    input  logic [7:0]  in_b,
    output logic [7:0]  out_a,
    output logic [7:0]  out_b,
    output logic        irq_out
);
    localparam int IN_W = PORT_W * N_PORTS;

    logic [3:0]                    dw;
    logic                          irq_s, hit, accept;
    logic [IN_W-1:0]               in_s, in_cap, in_view;
    logic [N_PORTS-1:0][PORT_W-1:0] out_q;
    ctl_state_t                    st;
    logic [31:0]                   rd_mux;

    assign dw = bus_addr[5:2];

    irqlat_sync #(.W(1), .STAGES(SYNC_STAGES)) u_irq_sync (
        .clk(clk), .rst(rst), .d(ext_irq), .q(irq_s));

    irqlat_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_in_sync (
        .clk(clk), .rst(rst), .d({in_b, in_a}), .q(in_s));

    irqlat_edge u_edge (
        .clk(clk), .rst(rst), .lvl(irq_s), .fall_sel(st.pol), .hit(hit));

    irqlat_csr u_csr (
        .clk(clk), .rst(rst), .wr(bus_wr), .dw(dw), .be(bus_be),
        .wdata(bus_wdata), .hit(hit), .accept(accept), .st(st));

    irqlat_capture #(.W(IN_W)) u_cap (
        .clk(clk), .rst(rst), .cap(accept && st.latch), .d(in_s), .q(in_cap));

    assign in_view = st.latch ? in_cap : in_s;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst)
                out_q[g] <= '0;
            else if (bus_wr && dw == DW_OUT && bus_be[g])
                out_q[g] <= bus_wdata[g*8 +: PORT_W];
        end
    end

    assign out_a   = out_q[0];
    assign out_b   = out_q[1];
    assign irq_out = st.pend & st.en;

    always_comb begin
        rd_mux = '0;
        case (dw)
            DW_IN:   rd_mux = {ctrl_byte(st), 8'h00, in_view};
            DW_OUT:  rd_mux = {16'h0000, out_q};
            DW_REV:  rd_mux = rev_word(REV_C2, REV_C3);
            DW_CSR:  rd_mux = csr_word(st);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> st.en); // R10
endmodule

// File: tb/tb_irqlat_top.sv
module tb_irqlat_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        ext_irq = 1'b0;
    logic [7:0]  in_a = '0;
    logic [7:0]  in_b = '0;
    logic [7:0]  out_a, out_b;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    irqlat_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_irq(ext_irq), .in_a(in_a), .in_b(in_b), .out_a(out_a), .out_b(out_b),
        .irq_out(irq_out));

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic brd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int m, input int k);
        return 8'(8'h11 * (k + 1)) ^ 8'(m * 8'h3C);
    endfunction

    initial begin
        logic [31:0] d;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
        chk("R1 out ports", {16'h0, out_b, out_a}, 32'h0);
        brd(6'h38, d); chk("R1 csr", d, 32'h0);
        brd(6'h04, d); chk("R1 outreg", d, 32'h0);
        brd(6'h00, d); chk("R1 ctrl", d & 32'hFF00_0000, 32'h0);

        // R2 output ports with byte lanes
        bwr(6'h04, 32'hDEAD_A55A, 4'b1111);
        chk("R2 pins", {16'h0, out_b, out_a}, 32'h0000_A55A);
        brd(6'h04, d); chk("R2 readback", d, 32'h0000_A55A);
        bwr(6'h04, 32'h0000_3C00, 4'b0010);
        brd(6'h04, d); chk("R2 lane1 only", d, 32'h0000_3C5A);
        bwr(6'h04, 32'h0000_FF7E, 4'b0001);
        chk("R2 lane0 only", {16'h0, out_b, out_a}, 32'h0000_3C7E);

        // R3 revision word, write ignored
        bwr(6'h34, 32'hFFFF_FFFF, 4'b1111);
        brd(6'h34, d); chk("R3 rev", d, 32'h3231_3041);

        // Mode sweep: R4 R5 R7 R8 R9 R10
        for (int m = 0; m < 4; m++) begin
            bit fl;
            bit lt;
            logic [15:0] p2, p3, p4;
            logic [31:0] ctl, base;
            fl = m[1]; lt = m[0];
            p2 = {pat(m, 2), pat(m, 1)};
            p3 = {pat(m, 4), pat(m, 3)};
            p4 = {pat(m, 6), pat(m, 5)};
            ctl = 32'(m) << 29;
            base = 32'h1000 | (32'(fl) << 6);
            bwr(6'h38, 32'h0, 4'b0010);
            ext_irq = fl; {in_b, in_a} = {pat(m, 0), pat(m, 7)};
            idle(6);
            bwr(6'h38, 32'h0082_0000, 4'b0100);
            bwr(6'h00, {1'b1, 2'(m), 5'b10101, 24'hFFFFFF}, 4'b1000);
            brd(6'h00, d); chk("R4 ctrl byte", d & 32'hFF00_0000, ctl);
            bwr(6'h38, 32'h0000_1000, 4'b0010);
            brd(6'h38, d); chk("R4 pol alias", d, base);
            {in_b, in_a} = p2; idle(6);
            ext_irq = ~fl;
            idle(3);
            chk("R10 irq after edge", {31'b0, irq_out}, 32'h1);
            {in_b, in_a} = p3; idle(6);
            brd(6'h00, d); chk("R9 first read", d, ctl | (lt ? p2 : p3));
            brd(6'h38, d); chk("R5 pending", d, base | 32'h0002_0000);
            ext_irq = fl; idle(6);
            brd(6'h38, d); chk("R5 opposite edge", d, base | 32'h0002_0000);
            {in_b, in_a} = p4; idle(6);
            ext_irq = ~fl; idle(6);
            brd(6'h38, d); chk("R7 missed", d, base | 32'h0082_0000);
            brd(6'h00, d); chk("R9 no recapture", d, ctl | (lt ? p2 : p4));
            bwr(6'h38, 32'h0002_0000, 4'b0100);
            idle(1);
            chk("R10 irq after clear", {31'b0, irq_out}, 32'h0);
            brd(6'h38, d); chk("R8 clear pend only", d, base | 32'h0080_0000);
            bwr(6'h38, 32'h0080_0000, 4'b0100);
            brd(6'h38, d); chk("R8 clear miss", d, base);
            ext_irq = fl; idle(6);
        end

        // R6 edges while disabled (falling mode, latch on from last mode)
        bwr(6'h38, 32'h0, 4'b0010);
        ext_irq = 1'b0; idle(6);
        ext_irq = 1'b1; idle(6);
        ext_irq = 1'b0; idle(6);
        brd(6'h38, d); chk("R6 disabled", d, 32'h0000_0040);
        chk("R6 irq low", {31'b0, irq_out}, 32'h0);
        bwr(6'h38, 32'h0000_1000, 4'b0010);
        idle(2);
        chk("R10 enable alone", {31'b0, irq_out}, 32'h0);

        // R4 polarity written through status byte 0
        bwr(6'h38, 32'h0000_0000, 4'b0001);
        brd(6'h00, d); chk("R4 csr pol 0", d & 32'hFF00_0000, 32'h2000_0000);
        bwr(6'h38, 32'hFFFF_FFFF, 4'b0001);
        brd(6'h00, d); chk("R4 csr pol 1", d & 32'hFF00_0000, 32'h6000_0000);

        // R11 reserved bits
        bwr(6'h38, 32'hFFFF_FFFF, 4'b1111);
        brd(6'h38, d); chk("R11 reserved", d, 32'h0000_1040);
        brd(6'h08, d); chk("R11 unmapped", d, 32'h0);

        done = 1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule